// File: doc/BRIEF.md
# Time-Triggered Bus Cycle Scheduler

This block produces the communication cycle timing for one node on a time-triggered automotive bus. One clock edge is one macrotick. Each cycle has three phases in a fixed order. The first is a static segment made of equal-length slots. The second is a dynamic segment counted in minislots, where slots stretch to fit the frames they carry. The last is a short idle network phase. At the start of every slot the scheduler reads that slot's transmit-pending flag and frame length from the host buffers. If a frame is pending, the scheduler drives it onto a parallel bus interface with start and end markers and pulses a clear back to the pending buffer. The cycle, slot and minislot counters, together with the current phase, are available as status outputs.

Slot numbers run from 0. The static slots come first, at indices 0 to NUM_STATIC_SLOTS-1. The dynamic slots follow them. A frame held in buffer k is always sent in slot k. Only one frame can be on the bus at a time.

Top module: `ttb_cycle_sched`

## Requirements
- R1: When `rst_n` is low at a clock edge, the next state has `cycle_cnt`, `slot_cnt` and `minislot_cnt` at zero, `phase` at 0 and the bus idle.
- R2: Phase codes are 0 for static, 1 for dynamic and 2 for idle. A cycle spends NUM_STATIC_SLOTS*STATIC_SLOT_MT macroticks in phase 0, then NUM_MINISLOTS*MINISLOT_MT in phase 1, then IDLE_MT in phase 2, and then phase 0 begins again. `cycle_cnt` adds one (wrapping) at the first macrotick of each new cycle. The bus is never active in phase 2.
- R3: In the static segment, `slot_cnt` advances by one every STATIC_SLOT_MT macroticks and `minislot_cnt` stays at 0. A pending frame starts TX_OFFSET_MT macroticks into its slot. It lasts max(L,1) macroticks, capped at STATIC_SLOT_MT-TX_OFFSET_MT, where L is the slot's length field. A slot with nothing pending still takes its full length, and the bus stays idle during it.
- R4: A dynamic slot whose frame is pending and fits starts the frame on the first macrotick of the slot. The frame is active for max(L,1) macroticks. The slot occupies ceil(max(L,1)/MINISLOT_MT) minislots, and `slot_cnt` then advances by one.
- R5: A dynamic slot with nothing pending lasts exactly one minislot, and then `slot_cnt` advances by one.
- R6: A frame fits only if `minislot_cnt` plus its minislot count is at most NUM_MINISLOTS. A pending dynamic frame that does not fit is not sent and its pending flag is not cleared. Its slot lasts one minislot.
- R7: `minislot_cnt` shows the index of the current minislot in phase 1 and holds NUM_MINISLOTS-1 in phase 2. Once every slot has been served, `slot_cnt` equals NUM_SLOTS and stays there through the rest of the dynamic segment and the idle phase, and the bus stays idle.
- R8: `bus_start` pulses on the first macrotick of a frame and `bus_end` on its last macrotick; both pulse on the same macrotick for a one-macrotick frame. `bus_active` is high for the whole frame. `bus_slot` carries the frame's slot index and does not change while the frame is active. At most one frame is active at a time.
- R9: `tx_clear` has exactly one bit set, the bit of the slot that starts, on the macrotick of `bus_start`. It is zero on every other macrotick.
- R10: With the default static parameters (10-macrotick slots, 1-macrotick offset), a 5-macrotick frame in slot 0 ends 6 macroticks after its slot begins. Its `bus_end` falls on macrotick 5 of the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one edge is one macrotick |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_pending | input | NUM_SLOTS | Bit k set: buffer k holds a frame for slot k |
| tx_len | input | NUM_SLOTS*LEN_W | Frame length in macroticks; slot k in bits [k*LEN_W +: LEN_W] |
| tx_clear | output | NUM_SLOTS | One-macrotick pulse clearing the buffer of the starting frame |
| bus_start | output | 1 | Start marker, first macrotick of a frame |
| bus_end | output | 1 | End marker, last macrotick of a frame |
| bus_active | output | 1 | A frame occupies the bus |
| bus_slot | output | SLOT_W | Slot index of the frame on the bus, 0 when idle |
| phase | output | 2 | 0 static, 1 dynamic, 2 idle |
| cycle_cnt | output | CYC_W | Communication cycle counter |
| slot_cnt | output | SLOT_W | Current slot index; NUM_SLOTS when all slots are served |
| minislot_cnt | output | MS_W | Current minislot index in the dynamic segment |

## Verification
The assertions check, on every cycle, the properties that hold without knowing the stimulus. These are: the phase order, the cycle counter stepping only at the idle-to-static boundary, that frames never overlap, that the slot index holds steady during a frame, that the clear pulse is one-hot and tied to the start marker, and that the bus is quiet after the last slot and in the idle phase. Only the bench scenarios can show the exact placement of each frame. That covers the static offset and length cap, the minislot count of each dynamic slot, the exact-fit boundary, a frame that does not fit being skipped, and the slots that fall past the end of the segment. The bench compares these against a per-macrotick timeline that it computes from the pending flags and lengths.

// File: rtl/ttb_pkg.sv
// Shared types and helpers for the time-triggered bus cycle scheduler.
// Assumes nothing beyond standard SystemVerilog.
package ttb_pkg;

    // Cycle phase encoding, visible on the phase port.
    typedef enum logic [1:0] {
        PH_STATIC  = 2'd0,
        PH_DYNAMIC = 2'd1,
        PH_IDLE    = 2'd2
    } phase_e;

    // Integer ceiling division; b must be positive.
    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

endpackage

// File: rtl/ttb_slot_select.sv
// Picks the pending flag and length of the current slot from the host
// buffers and derives the three frame sizes the scheduler needs: the
// static length (capped to the slot), the dynamic length, and the
// dynamic length in minislots. A zero length counts as one macrotick.
// Assumes slot_idx may equal NUM_SLOTS (no slot), which selects nothing.
module ttb_slot_select
    import ttb_pkg::*;
#(
    parameter int NUM_SLOTS      = 6,
    parameter int LEN_W          = 6,
    parameter int SLOT_W         = 3,
    parameter int STATIC_SLOT_MT = 10,
    parameter int TX_OFFSET_MT   = 1,
    parameter int MINISLOT_MT    = 2
) (
    input  logic [SLOT_W-1:0]          slot_idx,
    input  logic [NUM_SLOTS-1:0]       tx_pending,
    input  logic [NUM_SLOTS*LEN_W-1:0] tx_len,
    output logic                       sel_pending,
    output logic [LEN_W-1:0]           sel_static_mt,
    output logic [LEN_W-1:0]           sel_dyn_mt,
    output logic [LEN_W-1:0]           sel_dyn_ms
);

    localparam int STATIC_MAX = STATIC_SLOT_MT - TX_OFFSET_MT;

    logic [LEN_W-1:0] len_arr [NUM_SLOTS];
    logic [LEN_W-1:0] raw_len;
    int               eff_len;

    genvar g;
    generate
        for (g = 0; g < NUM_SLOTS; g++) begin : g_unpack
            assign len_arr[g] = tx_len[g*LEN_W +: LEN_W];
        end
    endgenerate

    // Multiplex the current slot's flag and length.
    always_comb begin
        sel_pending = 1'b0;
        raw_len     = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (int'(slot_idx) == i) begin
                sel_pending = tx_pending[i];
                raw_len     = len_arr[i];
            end
        end
    end

    // Derive the static, dynamic and minislot sizes of the selected frame.
    always_comb begin
        eff_len       = (raw_len == '0) ? 1 : int'(raw_len);
        sel_dyn_mt    = LEN_W'(eff_len);
        sel_static_mt = LEN_W'((eff_len > STATIC_MAX) ? STATIC_MAX : eff_len);
        sel_dyn_ms    = LEN_W'(ceil_div(eff_len, MINISLOT_MT));
    end

endmodule

// File: rtl/ttb_cycle_timer.sv
// Macrotick timebase and phase sequencer. It walks the static slots, the
// minislots of the dynamic segment and the idle phase, and it keeps the
// cycle, slot and minislot counters. It decides when a frame starts.
// Static frames start at a fixed offset into their slot. Dynamic frames
// start at the first macrotick of their slot, if they fit in the
// minislots left. Each dynamic slot is sized in one step from the frame
// length, without counting macroticks inside the frame.
// Assumes NUM_SLOTS > NUM_STATIC_SLOTS and TX_OFFSET_MT < STATIC_SLOT_MT.
module ttb_cycle_timer
    import ttb_pkg::*;
#(
    parameter int NUM_STATIC_SLOTS = 3,
    parameter int NUM_SLOTS        = 6,
    parameter int STATIC_SLOT_MT   = 10,
    parameter int TX_OFFSET_MT     = 1,
    parameter int MINISLOT_MT      = 2,
    parameter int NUM_MINISLOTS    = 20,
    parameter int IDLE_MT          = 2,
    parameter int LEN_W            = 6,
    parameter int SLOT_W           = 3,
    parameter int MS_W             = 5,
    parameter int CYC_W            = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_pending,
    input  logic [LEN_W-1:0]  sel_static_mt,
    input  logic [LEN_W-1:0]  sel_dyn_mt,
    input  logic [LEN_W-1:0]  sel_dyn_ms,
    output phase_e            phase_q,
    output logic [SLOT_W-1:0] slot_cnt,
    output logic [MS_W-1:0]   minislot_cnt,
    output logic [CYC_W-1:0]  cycle_cnt,
    output logic              start_now,
    output logic [LEN_W-1:0]  frame_mt
);

    localparam int MT_A   = (STATIC_SLOT_MT > MINISLOT_MT) ? STATIC_SLOT_MT : MINISLOT_MT;
    localparam int MT_MAX = (MT_A > IDLE_MT) ? MT_A : IDLE_MT;
    localparam int MT_W   = $clog2(MT_MAX + 1);

    logic [MT_W-1:0]  mt_cnt;
    logic [LEN_W-1:0] rem_ms;
    logic             new_slot;
    logic             dyn_open;
    logic             fits;
    logic             static_start;
    logic             dyn_start;
    logic [LEN_W-1:0] slot_ms;
    logic [LEN_W-1:0] cur_rem;

    // Start decision and sizing of the dynamic slot that opens now.
    always_comb begin
        dyn_open     = (phase_q == PH_DYNAMIC) && new_slot && (int'(slot_cnt) < NUM_SLOTS);
        fits         = (int'(minislot_cnt) + int'(sel_dyn_ms)) <= NUM_MINISLOTS;
        static_start = (phase_q == PH_STATIC) && (int'(mt_cnt) == TX_OFFSET_MT) && sel_pending;
        dyn_start    = dyn_open && sel_pending && fits;
        start_now    = static_start || dyn_start;
        frame_mt     = (phase_q == PH_STATIC) ? sel_static_mt : sel_dyn_mt;
        slot_ms      = dyn_start ? sel_dyn_ms : LEN_W'(1);
        cur_rem      = dyn_open ? (slot_ms - LEN_W'(1)) : rem_ms;
    end

    // Phase sequencing and counter updates, one step per macrotick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q      <= PH_STATIC;
            mt_cnt       <= '0;
            slot_cnt     <= '0;
            minislot_cnt <= '0;
            cycle_cnt    <= '0;
            rem_ms       <= '0;
            new_slot     <= 1'b0;
        end else begin
            case (phase_q)
                PH_STATIC: begin
                    if (int'(mt_cnt) == STATIC_SLOT_MT - 1) begin
                        mt_cnt   <= '0;
                        slot_cnt <= slot_cnt + SLOT_W'(1);
                        if (int'(slot_cnt) == NUM_STATIC_SLOTS - 1) begin
                            phase_q      <= PH_DYNAMIC;
                            new_slot     <= 1'b1;
                            minislot_cnt <= '0;
                        end
                    end else begin
                        mt_cnt <= mt_cnt + MT_W'(1);
                    end
                end
                PH_DYNAMIC: begin
                    if (int'(mt_cnt) == MINISLOT_MT - 1) begin
                        mt_cnt <= '0;
                        if (int'(minislot_cnt) == NUM_MINISLOTS - 1) begin
                            phase_q  <= PH_IDLE;
                            slot_cnt <= SLOT_W'(NUM_SLOTS);
                            new_slot <= 1'b0;
                        end else begin
                            minislot_cnt <= minislot_cnt + MS_W'(1);
                            if (int'(slot_cnt) < NUM_SLOTS) begin
                                if (cur_rem == '0) begin
                                    slot_cnt <= slot_cnt + SLOT_W'(1);
                                    new_slot <= 1'b1;
                                end else begin
                                    rem_ms   <= cur_rem - LEN_W'(1);
                                    new_slot <= 1'b0;
                                end
                            end
                        end
                    end else begin
                        mt_cnt <= mt_cnt + MT_W'(1);
                        if (dyn_open) begin
                            rem_ms   <= cur_rem;
                            new_slot <= 1'b0;
                        end
                    end
                end
                PH_IDLE: begin
                    if (int'(mt_cnt) == IDLE_MT - 1) begin
                        mt_cnt       <= '0;
                        phase_q      <= PH_STATIC;
                        slot_cnt     <= '0;
                        minislot_cnt <= '0;
                        cycle_cnt    <= cycle_cnt + CYC_W'(1);
                    end else begin
                        mt_cnt <= mt_cnt + MT_W'(1);
                    end
                end
                default: begin
                    phase_q <= PH_STATIC;
                    mt_cnt  <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/ttb_frame_tx.sv
// Bus-side frame shaper. On a start request it raises the start marker
// and the buffer clear for that slot in the same macrotick. It holds the
// bus active for the frame length and marks the last macrotick with the
// end marker.
// Assumes the timer never requests a start while a frame is in flight.
module ttb_frame_tx #(
    parameter int NUM_SLOTS = 6,
    parameter int LEN_W     = 6,
    parameter int SLOT_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_now,
    input  logic [LEN_W-1:0]     frame_mt,
    input  logic [SLOT_W-1:0]    slot_idx,
    output logic                 bus_start,
    output logic                 bus_end,
    output logic                 bus_active,
    output logic [SLOT_W-1:0]    bus_slot,
    output logic [NUM_SLOTS-1:0] tx_clear
);

    logic              busy;
    logic [LEN_W-1:0]  left_mt;
    logic [SLOT_W-1:0] cur_slot;

    // Markers and slot tag seen on the bus this macrotick.
    always_comb begin
        bus_start  = start_now;
        bus_active = start_now || busy;
        bus_end    = (start_now && (frame_mt <= LEN_W'(1))) || (busy && (left_mt == LEN_W'(1)));
        bus_slot   = start_now ? slot_idx : (busy ? cur_slot : '0);
    end

    genvar g;
    generate
        for (g = 0; g < NUM_SLOTS; g++) begin : g_clear
            assign tx_clear[g] = start_now && (int'(slot_idx) == g);
        end
    endgenerate

    // Track the macroticks left in the frame on the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            left_mt  <= '0;
            cur_slot <= '0;
        end else if (start_now) begin
            busy     <= frame_mt > LEN_W'(1);
            left_mt  <= frame_mt - LEN_W'(1);
            cur_slot <= slot_idx;
        end else if (busy) begin
            busy    <= left_mt > LEN_W'(1);
            left_mt <= left_mt - LEN_W'(1);
        end
    end

endmodule

// File: rtl/ttb_cycle_sched.sv
// Top of the time-triggered bus cycle scheduler. It connects the slot
// selector, the cycle timer and the frame shaper. One clock edge is one
// macrotick. The host holds tx_pending and tx_len steady; the block
// samples them when the matching slot comes up.
module ttb_cycle_sched
    import ttb_pkg::*;
#(
    parameter int NUM_STATIC_SLOTS = 3,
    parameter int NUM_DYN_SLOTS    = 3,
    parameter int STATIC_SLOT_MT   = 10,
    parameter int TX_OFFSET_MT     = 1,
    parameter int MINISLOT_MT      = 2,
    parameter int NUM_MINISLOTS    = 20,
    parameter int IDLE_MT          = 2,
    parameter int LEN_W            = 6,
    parameter int CYC_W            = 8,
    localparam int NUM_SLOTS       = NUM_STATIC_SLOTS + NUM_DYN_SLOTS,
    localparam int SLOT_W          = $clog2(NUM_SLOTS + 1),
    localparam int MS_W            = $clog2(NUM_MINISLOTS + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SLOTS-1:0]       tx_pending,
    input  logic [NUM_SLOTS*LEN_W-1:0] tx_len,
    output logic [NUM_SLOTS-1:0]       tx_clear,
    output logic                       bus_start,
    output logic                       bus_end,
    output logic                       bus_active,
    output logic [SLOT_W-1:0]          bus_slot,
    output logic [1:0]                 phase,
    output logic [CYC_W-1:0]           cycle_cnt,
    output logic [SLOT_W-1:0]          slot_cnt,
    output logic [MS_W-1:0]            minislot_cnt
);

    phase_e           phase_q;
    logic             sel_pending;
    logic [LEN_W-1:0] sel_static_mt;
    logic [LEN_W-1:0] sel_dyn_mt;
    logic [LEN_W-1:0] sel_dyn_ms;
    logic             start_now;
    logic [LEN_W-1:0] frame_mt;

    assign phase = phase_q;

    ttb_slot_select #(
        .NUM_SLOTS      (NUM_SLOTS),
        .LEN_W          (LEN_W),
        .SLOT_W         (SLOT_W),
        .STATIC_SLOT_MT (STATIC_SLOT_MT),
        .TX_OFFSET_MT   (TX_OFFSET_MT),
        .MINISLOT_MT    (MINISLOT_MT)
    ) sel_i (
        .slot_idx      (slot_cnt),
        .tx_pending    (tx_pending),
        .tx_len        (tx_len),
        .sel_pending   (sel_pending),
        .sel_static_mt (sel_static_mt),
        .sel_dyn_mt    (sel_dyn_mt),
        .sel_dyn_ms    (sel_dyn_ms)
    );

    ttb_cycle_timer #(
        .NUM_STATIC_SLOTS (NUM_STATIC_SLOTS),
        .NUM_SLOTS        (NUM_SLOTS),
        .STATIC_SLOT_MT   (STATIC_SLOT_MT),
        .TX_OFFSET_MT     (TX_OFFSET_MT),
        .MINISLOT_MT      (MINISLOT_MT),
        .NUM_MINISLOTS    (NUM_MINISLOTS),
        .IDLE_MT          (IDLE_MT),
        .LEN_W            (LEN_W),
        .SLOT_W           (SLOT_W),
        .MS_W             (MS_W),
        .CYC_W            (CYC_W)
    ) timer_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .sel_pending   (sel_pending),
        .sel_static_mt (sel_static_mt),
        .sel_dyn_mt    (sel_dyn_mt),
        .sel_dyn_ms    (sel_dyn_ms),
        .phase_q       (phase_q),
        .slot_cnt      (slot_cnt),
        .minislot_cnt  (minislot_cnt),
        .cycle_cnt     (cycle_cnt),
        .start_now     (start_now),
        .frame_mt      (frame_mt)
    );

    ttb_frame_tx #(
        .NUM_SLOTS (NUM_SLOTS),
        .LEN_W     (LEN_W),
        .SLOT_W    (SLOT_W)
    ) tx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_now  (start_now),
        .frame_mt   (frame_mt),
        .slot_idx   (slot_cnt),
        .bus_start  (bus_start),
        .bus_end    (bus_end),
        .bus_active (bus_active),
        .bus_slot   (bus_slot),
        .tx_clear   (tx_clear)
    );

endmodule

// File: rtl/ttb_cycle_sched_chk.sv
// Property checker for the cycle scheduler, attached by bind. It checks
// the phase order, the cycle counter step, frame exclusivity and the
// marker, clear and quiet-bus rules at the block's ports.
module ttb_cycle_sched_chk #(
    parameter int NUM_SLOTS = 6,
    parameter int SLOT_W    = 3,
    parameter int CYC_W     = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [1:0]           phase,
    input logic [CYC_W-1:0]     cycle_cnt,
    input logic [SLOT_W-1:0]    slot_cnt,
    input logic                 bus_start,
    input logic                 bus_end,
    input logic                 bus_active,
    input logic [SLOT_W-1:0]    bus_slot,
    input logic [NUM_SLOTS-1:0] tx_clear
);

    // R2: phases only move static -> dynamic -> idle -> static.
    assert_phase_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && phase != $past(phase)) |->
            ((phase == 2'd1 && $past(phase) == 2'd0) ||
             (phase == 2'd2 && $past(phase) == 2'd1) ||
             (phase == 2'd0 && $past(phase) == 2'd2)));

    // R2: the cycle counter changes only when idle hands over to static.
    assert_cycle_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && cycle_cnt != $past(cycle_cnt)) |->
            (phase == 2'd0 && $past(phase) == 2'd2));

    // R2: no frame in the idle phase.
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd2) |-> !bus_active);

    // R7: after the last slot, the dynamic segment stays quiet.
    assert_tail_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd1 && int'(slot_cnt) == NUM_SLOTS) |-> !bus_active);

    // R8: a new frame never starts on top of an unfinished one.
    assert_one_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && bus_start) |-> !($past(bus_active) && !$past(bus_end)));

    // R8: the end marker lies inside a frame.
    assert_end_in_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_end |-> bus_active);

    // R8: the slot tag holds during a frame.
    assert_slot_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && bus_active && !bus_start) |-> (bus_slot == $past(bus_slot)));

    // R9: a clear is a single bit and comes only with a start.
    assert_clear_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_clear != '0) |-> (bus_start && $countones(tx_clear) == 1));

    // R9: every start clears its buffer.
    assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |-> (tx_clear != '0));

endmodule

bind ttb_cycle_sched ttb_cycle_sched_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .SLOT_W    (SLOT_W),
    .CYC_W     (CYC_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase),
    .cycle_cnt  (cycle_cnt),
    .slot_cnt   (slot_cnt),
    .bus_start  (bus_start),
    .bus_end    (bus_end),
    .bus_active (bus_active),
    .bus_slot   (bus_slot),
    .tx_clear   (tx_clear)
);

// File: tb/ttb_cycle_sched_tb_top.sv
`timescale 1ns/1ps
// Bench for the cycle scheduler. Each cycle, a task builds the expected
// per-macrotick timeline from the pending flags and lengths; directed
// cycles cover the corner cases, then seeded random cycles follow.
module ttb_cycle_sched_tb_top;

    localparam int NSS    = 3;
    localparam int NDS    = 3;
    localparam int NS     = NSS + NDS;
    localparam int SMT    = 10;
    localparam int OFF    = 1;
    localparam int MS     = 2;
    localparam int NMS    = 20;
    localparam int IDL    = 2;
    localparam int LW     = 6;
    localparam int CW     = 8;
    localparam int SW     = $clog2(NS + 1);
    localparam int MW     = $clog2(NMS + 1);
    localparam int CYC_MT = NSS*SMT + NMS*MS + IDL;
    localparam int N_RAND = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NS-1:0]     tx_pending = '0;
    logic [NS*LW-1:0]  tx_len = '0;
    logic [NS-1:0]     tx_clear;
    logic              bus_start, bus_end, bus_active;
    logic [SW-1:0]     bus_slot;
    logic [1:0]        phase;
    logic [CW-1:0]     cycle_cnt;
    logic [SW-1:0]     slot_cnt;
    logic [MW-1:0]     minislot_cnt;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    int    len_a   [NS];
    int    e_phase [CYC_MT];
    int    e_slot  [CYC_MT];
    int    e_ms    [CYC_MT];
    bit    e_start [CYC_MT];
    bit    e_end   [CYC_MT];
    bit    e_act   [CYC_MT];
    int    e_bslot [CYC_MT];
    int    e_clear [CYC_MT];
    string e_tag   [CYC_MT];

    always #10 clk = ~clk;

    ttb_cycle_sched dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_pending   (tx_pending),
        .tx_len       (tx_len),
        .tx_clear     (tx_clear),
        .bus_start    (bus_start),
        .bus_end      (bus_end),
        .bus_active   (bus_active),
        .bus_slot     (bus_slot),
        .phase        (phase),
        .cycle_cnt    (cycle_cnt),
        .slot_cnt     (slot_cnt),
        .minislot_cnt (minislot_cnt)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int eff(input int l);
        return (l == 0) ? 1 : l;
    endfunction

    // Mark a frame of le macroticks starting at macrotick t0 for slot s.
    task automatic put_frame(input int t0, input int le, input int s);
        e_start[t0] = 1'b1;
        e_clear[t0] = 1 << s;
        e_end[t0 + le - 1] = 1'b1;
        for (int k = 0; k < le; k++) begin
            e_act[t0 + k]   = 1'b1;
            e_bslot[t0 + k] = s;
        end
    endtask

    // Build the expected cycle timeline from the requirements.
    task automatic build_expect();
        int base;
        int m;
        int cur;
        int n;
        int le;
        for (int t = 0; t < CYC_MT; t++) begin
            e_start[t] = 0; e_end[t] = 0; e_act[t] = 0;
            e_bslot[t] = 0; e_clear[t] = 0;
        end
        for (int s = 0; s < NSS; s++) begin
            for (int j = 0; j < SMT; j++) begin
                e_phase[s*SMT + j] = 0;
                e_slot[s*SMT + j]  = s;
                e_ms[s*SMT + j]    = 0;
                e_tag[s*SMT + j]   = "R3";
            end
            if (tx_pending[s]) begin
                le = eff(len_a[s]);
                if (le > SMT - OFF) le = SMT - OFF;
                put_frame(s*SMT + OFF, le, s);
            end
        end
        base = NSS*SMT;
        m = 0;
        cur = NSS;
        while (m < NMS) begin
            string tg;
            if (cur < NS) begin
                le = eff(len_a[cur]);
                n  = (le + MS - 1) / MS;
                if (tx_pending[cur] && (m + n <= NMS)) begin
                    put_frame(base + m*MS, le, cur);
                    tg = "R4";
                end else begin
                    tg = tx_pending[cur] ? "R6" : "R5";
                    n  = 1;
                end
                for (int j = 0; j < n*MS; j++) begin
                    e_phase[base + m*MS + j] = 1;
                    e_slot[base + m*MS + j]  = cur;
                    e_ms[base + m*MS + j]    = m + j / MS;
                    e_tag[base + m*MS + j]   = tg;
                end
                m += n;
                cur++;
            end else begin
                for (int j = 0; j < MS; j++) begin
                    e_phase[base + m*MS + j] = 1;
                    e_slot[base + m*MS + j]  = NS;
                    e_ms[base + m*MS + j]    = m;
                    e_tag[base + m*MS + j]   = "R7";
                end
                m++;
            end
        end
        for (int i = 0; i < IDL; i++) begin
            e_phase[base + NMS*MS + i] = 2;
            e_slot[base + NMS*MS + i]  = NS;
            e_ms[base + NMS*MS + i]    = NMS - 1;
            e_tag[base + NMS*MS + i]   = "R7";
        end
    endtask

    task automatic apply_inputs(input logic [NS-1:0] pend);
        tx_pending = pend;
        for (int s = 0; s < NS; s++) tx_len[s*LW +: LW] = LW'(len_a[s]);
    endtask

    // Compare every output at macrotick t of cycle cyc.
    task automatic check_mt(input int cyc, input int t);
        check(int'(phase) == e_phase[t], "R2", "phase", int'(phase), e_phase[t]);
        check(int'(cycle_cnt) == cyc % 256, "R2", "cycle_cnt", int'(cycle_cnt), cyc % 256);
        check(int'(slot_cnt) == e_slot[t], e_tag[t], "slot_cnt", int'(slot_cnt), e_slot[t]);
        check(int'(minislot_cnt) == e_ms[t], (e_phase[t] == 0) ? "R3" : "R7",
              "minislot_cnt", int'(minislot_cnt), e_ms[t]);
        check(bus_start == e_start[t], "R8", "bus_start", int'(bus_start), int'(e_start[t]));
        check(bus_end == e_end[t], "R8", "bus_end", int'(bus_end), int'(e_end[t]));
        check(bus_active == e_act[t], "R8", "bus_active", int'(bus_active), int'(e_act[t]));
        check(int'(bus_slot) == e_bslot[t], "R8", "bus_slot", int'(bus_slot), e_bslot[t]);
        check(int'(tx_clear) == e_clear[t], "R9", "tx_clear", int'(tx_clear), e_clear[t]);
        if (cyc == 0 && t == 5)
            check(bus_end == 1'b1, "R10", "bus_end at macrotick 5", int'(bus_end), 1);
    endtask

    task automatic check_reset_state();
        check(int'(phase) == 0, "R1", "phase", int'(phase), 0);
        check(cycle_cnt == '0, "R1", "cycle_cnt", int'(cycle_cnt), 0);
        check(slot_cnt == '0, "R1", "slot_cnt", int'(slot_cnt), 0);
        check(minislot_cnt == '0, "R1", "minislot_cnt", int'(minislot_cnt), 0);
        check(bus_active == 1'b0, "R1", "bus_active", int'(bus_active), 0);
    endtask

    initial begin
        logic [NS-1:0] pend;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        #1;
        check_reset_state();
        rst_n = 1'b1;
        for (int cyc = 0; cyc < 4 + N_RAND; cyc++) begin
            if (cyc > 0) @(negedge clk);
            case (cyc)
                0: begin len_a = '{5, 0, 0, 0, 7, 0};    pend = 6'b010001; end
                1: begin len_a = '{0, 9, 20, 1, 38, 3};  pend = 6'b111111; end
                2: begin len_a = '{4, 4, 4, 2, 40, 4};   pend = 6'b111000; end
                3: begin len_a = '{3, 3, 3, 3, 3, 3};    pend = 6'b000000; end
                default: begin
                    for (int s = 0; s < NS; s++) len_a[s] = $urandom_range(0, 63);
                    pend = NS'($urandom);
                end
            endcase
            apply_inputs(pend);
            build_expect();
            #1;
            check_mt(cyc, 0);
            for (int t = 1; t < CYC_MT; t++) begin
                @(negedge clk);
                #1;
                check_mt(cyc, t);
            end
        end
        repeat (41) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        check_reset_state();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule